// File: doc/BRIEF.md
# Six-Port Table-Routed Packet Crossbar

This block switches packets between six ports. Each port has its own inbound and outbound 16-bit flit path with valid/ready handshaking, and all six paths work at the same time. A packet is a run of flits ending with one flagged last. Its first flit, the header, carries a 6-bit destination in its low bits. A 64-entry table, written through a simple write port, turns that destination into an output port. Because the table is written freely, any node count can be mapped and traffic can be steered around a failed link.

Each output is claimed by one input for the whole length of a packet. When several inputs ask for a free output, the one whose header has waited longest wins. Headers whose table entry is not usable are swallowed whole, and a saturating counter records each such packet. Flits pass through combinationally, so a header can leave on the cycle it arrives. A stalled output holds back only the input that owns it.

Top module: `xbar_router`

## Requirements
- R1: After reset every outValid bit is 0, errCount is 0, and every table entry is unusable.
- R2: A header's destination is inData bits [5:0] of its port. When the entry for that destination is usable, the header and every later flit of the packet appear unchanged, with their last flag, on the output the entry names, in the same cycle they are presented. A table write is seen by headers from the following cycle on.
- R3: A free output is granted to the requesting header that has waited the most cycles. Among equal waits, the lowest input number wins.
- R4: Once a header is accepted on an output, that output carries only flits of that input until the flit with inLast=1 has been accepted. Other headers for it keep inReady low.
- R5: A header whose entry has tblValid=0, or whose port is 6 or more, is dropped with every later flit of its packet. inReady is held 1, no output shows those flits, and errCount rises by one for each packet, stopping at its maximum of 255.
- R6: Packets from different inputs to different outputs all move in the same cycle, up to all six at once.
- R7: When outReady of an output is 0, only the input that owns that output sees inReady 0. Other inputs keep moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 6 | Flit present on each input |
| inData | input | 96 | Input flits, port p at bits [16p+15:16p] |
| inLast | input | 6 | Flit is the last of its packet |
| inReady | output | 6 | Input flit accepted this cycle |
| outValid | output | 6 | Flit present on each output |
| outData | output | 96 | Output flits, port p at bits [16p+15:16p] |
| outLast | output | 6 | Output flit is the last of its packet |
| outReady | input | 6 | Downstream accepts the output flit |
| tblWe | input | 1 | Write one routing table entry |
| tblAddr | input | 6 | Destination being written |
| tblPort | input | 3 | Output port for that destination |
| tblValid | input | 1 | Entry is usable |
| errCount | output | 8 | Dropped packet count, saturating |

## Verification
The bench builds an age race on a shared output. An older request on a higher port must beat a newer one on a lower port, and an arbiter that only looked at port order would hand the output to the newcomer. While a three-flit packet holds the output, other headers are kept waiting, which catches a switch that arbitrates again on every flit and mixes packets. Dropping is tested for a clear valid bit, for a port number past the last port, for a table write made in the same cycle as the header, and for a multi-flit packet that must count once. Counter saturation is also checked. A stalled output must not freeze an unrelated input, and all six ports are driven at once to show the crossbar does not block.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int SelW = 3;

  typedef enum logic [1:0] {
    InIdle,
    InFwd,
    InDrop
  } inState_e;

  typedef struct packed {
    logic            en;
    logic [SelW-1:0] sel;
  } outStrobe_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int NumPorts = 6,
  parameter int DestW    = 6,
  parameter int AgeW     = 4,
  parameter int ErrW     = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumPorts-1:0]       inValid,
  input  logic [NumPorts*DestW-1:0] inDest,
  input  logic [NumPorts-1:0]       inLast,
  input  logic [NumPorts-1:0]       inReady,
  input  logic [NumPorts-1:0]       outReady,
  input  logic                      tblWe,
  input  logic [DestW-1:0]          tblAddr,
  input  logic [SelW-1:0]           tblPort,
  input  logic                      tblValid,
  output outStrobe_t [NumPorts-1:0] outSel,
  output logic [NumPorts-1:0]       dropRdy,
  output logic [ErrW-1:0]           errCount
);
  localparam int Depth = 1 << DestW;

  logic            tblOk   [Depth];
  logic [SelW-1:0] tblDest [Depth];

  inState_e        inState [NumPorts];
  logic [AgeW-1:0] age     [NumPorts];
  logic [NumPorts-1:0] outLocked;
  logic [SelW-1:0]     outOwner [NumPorts];

  logic [NumPorts-1:0] headReq, hit, fire, newDrop;
  logic [SelW-1:0]     wantOut [NumPorts];
  logic [ErrW:0]       errSum;
  logic [ErrW-1:0]     errNext;

  // routing table, written one entry per cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < Depth; d++) begin
        tblOk[d]   <= 1'b0;
        tblDest[d] <= '0;
      end
    end else if (tblWe) begin
      tblOk[tblAddr]   <= tblValid;
      tblDest[tblAddr] <= tblPort;
    end
  end

  // header lookup per input
  always_comb begin
    for (int i = 0; i < NumPorts; i++) begin
      wantOut[i] = tblDest[inDest[i*DestW +: DestW]];
      hit[i]     = tblOk[inDest[i*DestW +: DestW]] && (int'(wantOut[i]) < NumPorts);
      headReq[i] = inValid[i] && (inState[i] == InIdle);
      fire[i]    = inValid[i] && inReady[i];
      newDrop[i] = headReq[i] && !hit[i] && fire[i];
      dropRdy[i] = (headReq[i] && !hit[i]) || (inState[i] == InDrop);
    end
  end

  // per-output arbitration: oldest header wins, ties to lowest port
  always_comb begin
    logic            found;
    logic [AgeW-1:0] best;
    for (int o = 0; o < NumPorts; o++) begin
      outSel[o] = '0;
      found     = 1'b0;
      best      = '0;
      if (outLocked[o]) begin
        outSel[o].en  = 1'b1;
        outSel[o].sel = outOwner[o];
      end else begin
        for (int i = 0; i < NumPorts; i++) begin
          if (headReq[i] && hit[i] && (wantOut[i] == SelW'(o)) &&
              (!found || (age[i] > best))) begin
            found         = 1'b1;
            best          = age[i];
            outSel[o].en  = 1'b1;
            outSel[o].sel = SelW'(i);
          end
        end
      end
    end
  end

  always_comb begin
    errSum = {1'b0, errCount};
    for (int i = 0; i < NumPorts; i++) errSum = errSum + {{ErrW{1'b0}}, newDrop[i]};
    errNext = errSum[ErrW] ? '1 : errSum[ErrW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumPorts; i++) begin
        inState[i] <= InIdle;
        age[i]     <= '0;
      end
      for (int o = 0; o < NumPorts; o++) begin
        outLocked[o] <= 1'b0;
        outOwner[o]  <= '0;
      end
      errCount <= '0;
    end else begin
      for (int i = 0; i < NumPorts; i++) begin
        case (inState[i])
          InIdle: begin
            if (fire[i]) begin
              age[i] <= '0;
              if (!inLast[i]) inState[i] <= hit[i] ? InFwd : InDrop;
            end else if (headReq[i] && (age[i] != '1)) begin
              age[i] <= age[i] + 1'b1;
            end
          end
          default: if (fire[i] && inLast[i]) inState[i] <= InIdle;
        endcase
      end
      for (int o = 0; o < NumPorts; o++) begin
        if (outLocked[o]) begin
          if (fire[outOwner[o]] && inLast[outOwner[o]]) outLocked[o] <= 1'b0;
        end else if (outSel[o].en && fire[outSel[o].sel] && !inLast[outSel[o].sel]) begin
          outLocked[o] <= 1'b1;
          outOwner[o]  <= outSel[o].sel;
        end
      end
      errCount <= errNext;
    end
  end

  // R3 check: a fresh grant never passes over an older requester
  logic [NumPorts-1:0] olderSkipped;
  always_comb begin
    for (int o = 0; o < NumPorts; o++) begin
      olderSkipped[o] = 1'b0;
      if (!outLocked[o] && outSel[o].en)
        for (int i = 0; i < NumPorts; i++)
          if (headReq[i] && hit[i] && (wantOut[i] == SelW'(o)) && (age[i] > age[outSel[o].sel]))
            olderSkipped[o] = 1'b1;
    end
  end

  a_r3_oldest_wins: assert property (@(posedge clk) disable iff (!rstN) olderSkipped == '0);

  a_r5_err_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> errCount >= $past(errCount));

  for (genvar g = 0; g < NumPorts; g++) begin : g_chk
    a_r4_lock_held: assert property (@(posedge clk) disable iff (!rstN)
      outLocked[g] && !(fire[outOwner[g]] && inLast[outOwner[g]])
      |=> outLocked[g] && (outOwner[g] == $past(outOwner[g])));
    a_r7_stall_owner: assert property (@(posedge clk) disable iff (!rstN)
      outLocked[g] && !outReady[g] |-> !inReady[outOwner[g]]);
    a_r5_drop_ready: assert property (@(posedge clk) disable iff (!rstN)
      inState[g] == InDrop |-> inReady[g]);
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int NumPorts = 6,
  parameter int FlitW    = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumPorts-1:0]       inValid,
  input  logic [NumPorts*FlitW-1:0] inData,
  input  logic [NumPorts-1:0]       inLast,
  input  logic [NumPorts-1:0]       outReady,
  input  outStrobe_t [NumPorts-1:0] outSel,
  input  logic [NumPorts-1:0]       dropRdy,
  output logic [NumPorts-1:0]       inReady,
  output logic [NumPorts-1:0]       outValid,
  output logic [NumPorts*FlitW-1:0] outData,
  output logic [NumPorts-1:0]       outLast
);
  logic [NumPorts-1:0] useMat [NumPorts];

  always_comb begin
    for (int o = 0; o < NumPorts; o++) begin
      outValid[o]                = outSel[o].en && inValid[outSel[o].sel];
      outData[o*FlitW +: FlitW]  = inData[outSel[o].sel*FlitW +: FlitW];
      outLast[o]                 = outSel[o].en && inLast[outSel[o].sel];
    end
    for (int i = 0; i < NumPorts; i++) begin
      inReady[i] = dropRdy[i];
      useMat[i]  = '0;
      for (int o = 0; o < NumPorts; o++) begin
        if (outSel[o].en && (outSel[o].sel == SelW'(i))) begin
          useMat[i][o] = 1'b1;
          if (outReady[o]) inReady[i] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NumPorts; g++) begin : g_chk
    a_r6_one_output: assert property (@(posedge clk) disable iff (!rstN) $onehot0(useMat[g]));
  end
endmodule

// File: rtl/xbar_router.sv
module xbar_router
  import xbar_pkg::*;
#(
  parameter int NumPorts = 6,
  parameter int FlitW    = 16,
  parameter int DestW    = 6,
  parameter int AgeW     = 4,
  parameter int ErrW     = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumPorts-1:0]       inValid,
  input  logic [NumPorts*FlitW-1:0] inData,
  input  logic [NumPorts-1:0]       inLast,
  output logic [NumPorts-1:0]       inReady,
  output logic [NumPorts-1:0]       outValid,
  output logic [NumPorts*FlitW-1:0] outData,
  output logic [NumPorts-1:0]       outLast,
  input  logic [NumPorts-1:0]       outReady,
  input  logic                      tblWe,
  input  logic [DestW-1:0]          tblAddr,
  input  logic [SelW-1:0]           tblPort,
  input  logic                      tblValid,
  output logic [ErrW-1:0]           errCount
);
  outStrobe_t [NumPorts-1:0] outSel;
  logic [NumPorts-1:0]       dropRdy;
  logic [NumPorts*DestW-1:0] inDest;

  for (genvar g = 0; g < NumPorts; g++) begin : g_dest
    assign inDest[g*DestW +: DestW] = inData[g*FlitW +: DestW];
  end

  xbar_ctrl #(.NumPorts(NumPorts), .DestW(DestW), .AgeW(AgeW), .ErrW(ErrW)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest), .inLast(inLast),
    .inReady(inReady), .outReady(outReady), .tblWe(tblWe), .tblAddr(tblAddr),
    .tblPort(tblPort), .tblValid(tblValid), .outSel(outSel), .dropRdy(dropRdy),
    .errCount(errCount)
  );

  xbar_datapath #(.NumPorts(NumPorts), .FlitW(FlitW)) i_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .outReady(outReady), .outSel(outSel), .dropRdy(dropRdy), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );
endmodule

// File: tb/test_xbar_router.sv
module test_xbar_router;
  localparam int NP = 6;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rstN;
  logic [NP-1:0]    inValid, inLast, inReady, outValid, outLast, outReady;
  logic [NP*FW-1:0] inData, outData;
  logic             tblWe, tblValid;
  logic [5:0]       tblAddr;
  logic [2:0]       tblPort;
  logic [7:0]       errCount;

  int checks = 0;
  int errors = 0;
  int expErr = 0;

  always #4 clk = ~clk;

  xbar_router i_xbar_router (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outLast(outLast),
    .outReady(outReady), .tblWe(tblWe), .tblAddr(tblAddr), .tblPort(tblPort),
    .tblValid(tblValid), .errCount(errCount)
  );

  typedef struct packed {
    logic [2:0] src;
    logic [5:0] dest;
    logic [2:0] port;
    logic [9:0] pay;
  } vec_t;

  localparam vec_t Vecs [6] = '{
    '{3'd0, 6'd32, 3'd3, 10'h155},
    '{3'd1, 6'd33, 3'd5, 10'h0AA},
    '{3'd2, 6'd34, 3'd0, 10'h3C3},
    '{3'd3, 6'd35, 3'd4, 10'h012},
    '{3'd4, 6'd36, 3'd1, 10'h2F0},
    '{3'd5, 6'd37, 3'd2, 10'h1E7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nextCyc;
    @(negedge clk);
  endtask

  task automatic setIn(input int i, input logic [15:0] d, input logic l);
    inValid[i] = 1'b1;
    inData[i*FW +: FW] = d;
    inLast[i] = l;
  endtask

  task automatic clrIn(input int i);
    inValid[i] = 1'b0;
    inLast[i]  = 1'b0;
  endtask

  task automatic wrTbl(input logic [5:0] d, input logic [2:0] p, input logic ok);
    tblWe = 1'b1; tblAddr = d; tblPort = p; tblValid = ok;
    nextCyc();
    tblWe = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = '0; inLast = '0; inData = '0; outReady = '1;
    tblWe = 1'b0; tblAddr = '0; tblPort = '0; tblValid = 1'b0;
    nextCyc(); nextCyc();
    #1;
    chk("R1 outValid in reset", 32'(outValid), 32'h0);
    chk("R1 errCount in reset", 32'(errCount), 32'h0);
    rstN = 1'b1;
    nextCyc();

    // R1 / R5: table starts unusable, so the header is swallowed
    setIn(0, 16'h1209, 1'b1);
    #1;
    chk("R1 empty table inReady", 32'(inReady[0]), 32'h1);
    chk("R1 empty table outValid", 32'(outValid), 32'h0);
    nextCyc(); clrIn(0); expErr++;
    #1 chk("R5 errCount after drop", 32'(errCount), 32'(expErr));

    // R5: port number past the last port, three-flit packet counts once
    wrTbl(6'd10, 3'd7, 1'b1);
    setIn(2, 16'h000A, 1'b0);
    #1 chk("R5 port7 hdr ready", 32'(inReady[2]), 32'h1);
    chk("R5 port7 hdr no out", 32'(outValid), 32'h0);
    nextCyc();
    setIn(2, 16'hFFFF, 1'b0);
    #1 chk("R5 drop body ready", 32'(inReady[2]), 32'h1);
    chk("R5 drop body no out", 32'(outValid), 32'h0);
    nextCyc();
    setIn(2, 16'h5555, 1'b1);
    #1 chk("R5 drop tail ready", 32'(inReady[2]), 32'h1);
    nextCyc(); clrIn(2); expErr++;
    #1 chk("R5 multi-flit counts once", 32'(errCount), 32'(expErr));

    // R2: a write in the same cycle as the header is not yet seen
    tblWe = 1'b1; tblAddr = 6'd40; tblPort = 3'd1; tblValid = 1'b1;
    setIn(0, 16'h0028, 1'b1);
    #1 chk("R2 same-cycle write drops", 32'(outValid), 32'h0);
    nextCyc(); tblWe = 1'b0; expErr++;
    #1 chk("R2 route live next cycle", 32'(outValid), 32'h2);
    chk("R2 data on port1", 32'(outData[1*FW +: FW]), 32'h0028);
    chk("R5 errCount same-cycle", 32'(errCount), 32'(expErr));
    nextCyc(); clrIn(0);

    // R2: vector table, one routed single-flit packet each
    for (int k = 0; k < 6; k++) begin
      wrTbl(Vecs[k].dest, Vecs[k].port, 1'b1);
      setIn(int'(Vecs[k].src), {Vecs[k].pay, Vecs[k].dest}, 1'b1);
      #1;
      chk("R2 vec outValid", 32'(outValid), 32'(6'b1 << Vecs[k].port));
      chk("R2 vec outData", 32'(outData[Vecs[k].port*FW +: FW]), 32'({Vecs[k].pay, Vecs[k].dest}));
      chk("R2 vec outLast", 32'(outLast[Vecs[k].port]), 32'h1);
      chk("R2 vec inReady", 32'(inReady[Vecs[k].src]), 32'h1);
      nextCyc();
      clrIn(int'(Vecs[k].src));
    end

    // R6: all six ports at once through a permutation
    for (int k = 0; k < 6; k++) setIn(int'(Vecs[k].src), {Vecs[k].pay, Vecs[k].dest}, 1'b1);
    #1;
    chk("R6 all outputs valid", 32'(outValid), 32'h3F);
    chk("R6 all inputs ready", 32'(inReady), 32'h3F);
    for (int k = 0; k < 6; k++)
      chk("R6 permuted data", 32'(outData[Vecs[k].port*FW +: FW]), 32'({Vecs[k].pay, Vecs[k].dest}));
    nextCyc();
    inValid = '0; inLast = '0;

    // R3 / R4: lock, tie break and age order on output 2
    wrTbl(6'd1, 3'd2, 1'b1);
    setIn(1, 16'hA001, 1'b0);
    setIn(3, 16'hB001, 1'b1);
    #1 chk("R3 tie to lowest port data", 32'(outData[2*FW +: FW]), 32'hA001);
    chk("R3 tie loser waits", 32'(inReady[3]), 32'h0);
    chk("R3 tie winner ready", 32'(inReady[1]), 32'h1);
    nextCyc();
    setIn(1, 16'hA111, 1'b0);
    #1 chk("R4 body follows owner", 32'(outData[2*FW +: FW]), 32'hA111);
    chk("R4 other header held", 32'(inReady[3]), 32'h0);
    nextCyc();
    setIn(1, 16'hA222, 1'b1);
    setIn(0, 16'hC001, 1'b1);
    #1 chk("R4 tail follows owner", 32'(outData[2*FW +: FW]), 32'hA222);
    chk("R4 tail last flag", 32'(outLast[2]), 32'h1);
    chk("R4 newcomer held", 32'(inReady[0]), 32'h0);
    nextCyc(); clrIn(1);
    #1 chk("R3 oldest wins", 32'(outData[2*FW +: FW]), 32'hB001);
    chk("R3 younger low port waits", 32'(inReady[0]), 32'h0);
    chk("R3 oldest ready", 32'(inReady[3]), 32'h1);
    nextCyc(); clrIn(3);
    #1 chk("R3 younger served next", 32'(outData[2*FW +: FW]), 32'hC001);
    chk("R3 younger ready", 32'(inReady[0]), 32'h1);
    nextCyc(); clrIn(0);

    // R7: stall on output 4 does not hold input 5 bound for output 5
    wrTbl(6'd2, 3'd4, 1'b1);
    wrTbl(6'd3, 3'd5, 1'b1);
    outReady[4] = 1'b0;
    setIn(2, 16'h0402, 1'b1);
    setIn(5, 16'h0503, 1'b1);
    #1 chk("R7 stalled output valid", 32'(outValid[5:4]), 32'h3);
    chk("R7 owner stalled", 32'(inReady[2]), 32'h0);
    chk("R7 other input moves", 32'(inReady[5]), 32'h1);
    nextCyc(); clrIn(5);
    #1 chk("R7 stalled flit held", 32'(outData[4*FW +: FW]), 32'h0402);
    chk("R7 still stalled", 32'(inReady[2]), 32'h0);
    outReady[4] = 1'b1;
    #1 chk("R7 released", 32'(inReady[2]), 32'h1);
    nextCyc(); clrIn(2);

    // R5: counter saturates at 255
    setIn(0, 16'h0009, 1'b1);
    for (int k = 0; k < 260; k++) nextCyc();
    clrIn(0);
    #1 chk("R5 errCount saturates", 32'(errCount), 32'd255);
    setIn(4, 16'h0009, 1'b1);
    nextCyc(); clrIn(4);
    #1 chk("R5 errCount stays saturated", 32'(errCount), 32'd255);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule